// File: doc/BRIEF.md
# DMA Channel Request Selector

This block holds the 32-bit control word of one DMA channel and decides, cycle by cycle, whether the channel's transfer engine should be started. Nine request sources compete for the channel. Six are level status lines from on-chip peripherals. Three are external interrupt pins, which may change at any time relative to the clock. Software enables or masks each source through a nine-bit field of the control word. A single output, `trig`, asks the transfer engine for one transfer.

Each internal source counts only while the channel enable bit of the control word is set. It then drives `trig` high in every cycle that its status line is high. Each external pin first passes through a synchronizer. Only a rising edge of the synchronized value counts, and it yields a pulse one cycle long. An edge that arrives while the channel is disabled is dropped, so a stale edge cannot start a transfer once the channel is enabled. A software reset input clears the mask field and leaves the other fields as they are. Unused positions in the control word always read as zero.

Top module: `dma_req_select`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the whole control word clears to zero and `trig` is low.
- R2: When `wr_en` is high at a rising edge, the control word takes `wr_data` at that edge. `rd_data` shows the stored word without delay. With `wr_en` low, the word does not change.
- R3: Bit positions 6, 7, 17 to 22, 27 and 29 always read as zero, and writing them has no effect. Writing all ones therefore reads back as 32'hD781FF3F.
- R4: Field positions are as follows. Channel enable is bit 31. Interrupt enable is bit 30. Transfer-done flag is bit 28. Transfer mode is bits 26:25. Priority is bit 24. Continuous flag is bit 23. Request mask is bits 16:8. Source space is bits 5:3. Destination space is bits 2:0. Every writable field reads back exactly as written.
- R5: Mask bit i sits at control bit 8+i. For i from 0 to 5 it selects `int_stat[i]`. For i from 6 to 8 it selects `ext_pin[i-6]`. A source whose mask bit is clear never raises `trig`.
- R6: `trig` is high in every cycle in which a selected internal status line is high and the channel enable bit is set. There is no register on this path.
- R7: A rising edge on a selected external pin, with the pin held across the clock edges, raises `trig` for exactly one cycle. That cycle begins at the third rising clock edge after the pin changes. A pin that stays high, or a falling edge, produces no further pulse.
- R8: An external edge produces no pulse if the channel enable bit is clear when the edge is detected. Later setting the enable bit while the pin is already high does not produce a pulse either.
- R9: `soft_rst` high at a rising edge clears the mask field, overriding any write in that cycle. All other fields keep their value.
- R10: `trig` is the OR of all selected sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Software reset; clears the mask field |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Current control word, with unused bits reading zero |
| int_stat | input | 6 | Internal peripheral request status lines |
| ext_pin | input | 3 | Asynchronous external request pins |
| trig | output | 1 | Transfer request toward the transfer engine |

## Verification
A corrupt control word shows up on `rd_data` in the cycle after the write that caused it. An internal source that is gated wrongly shows up on `trig` in the same cycle as the status line. A fault in the synchronizer or the edge detector shifts, doubles or drops the external pulse. The bench would see this within three or four cycles of the pin change, because it expects the pulse in exactly one cycle. A stale edge that survives a disabled period shows up as an unexpected pulse right after the enable bit is set.

// File: rtl/dma_rsel_pkg.sv
`timescale 1ns/1ps
// Package: shared layout of the channel control word and source counts.
// Assumes a fixed 32-bit word with nine mask bits split 6 internal / 3 external.
package dma_rsel_pkg;

    localparam int N_INT = 6;
    localparam int N_EXT = 3;
    localparam int N_SRC = N_INT + N_EXT;
    localparam int WORD_W = 32;

    // Positions that always read zero.
    localparam logic [WORD_W-1:0] RSV_BITS = 32'h287E_00C0;

    typedef struct packed {
        logic             chan_en;    // 31
        logic             irq_en;     // 30
        logic             rsv29;      // 29
        logic             done_flag;  // 28
        logic             rsv27;      // 27
        logic [1:0]       xfer_mode;  // 26:25
        logic             prio;       // 24
        logic             cont;       // 23
        logic [5:0]       rsv22_17;   // 22:17
        logic [N_SRC-1:0] req_mask;   // 16:8
        logic [1:0]       rsv7_6;     // 7:6
        logic [2:0]       src_space;  // 5:3
        logic [2:0]       dst_space;  // 2:0
    } ctl_word_t;

endpackage

// File: rtl/dma_ctl_reg.sv
`timescale 1ns/1ps
// Module: control word register.
// Holds the channel control word. Unused positions are stored as zero.
// Assumes soft_rst affects only the mask field and wins over a same-cycle write.
module dma_ctl_reg
    import dma_rsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctl_word_t         ctl
);

    ctl_word_t ctl_q;

    // Purpose: load on write, clear the mask on software reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (wr_en) begin
                ctl_q <= ctl_word_t'(wr_data & ~RSV_BITS);
            end
            if (soft_rst) begin
                ctl_q.req_mask <= '0;
            end
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/dma_ext_edge.sv
`timescale 1ns/1ps
// Module: external pin synchronizer and rising-edge detector.
// Passes one asynchronous pin through STAGES flops. It emits a registered
// one-cycle pulse on a rising edge of the synchronized value, but only
// while arm is high. Assumes STAGES >= 2.
module dma_ext_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic arm,
    output logic pulse
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              pulse_q;

    // Purpose: move the pin into the clock domain and keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Purpose: register a single-cycle pulse on a qualified rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= arm & sync_q[STAGES-1] & ~prev_q;
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/dma_trig_merge.sv
`timescale 1ns/1ps
// Module: trigger merge.
// Gates internal status lines by mask and channel enable, then ORs them
// with the already qualified external pulses. Pure combinational logic.
module dma_trig_merge #(
    parameter int N_I = 6,
    parameter int N_E = 3
) (
    input  logic [N_I-1:0] int_stat,
    input  logic [N_I-1:0] int_mask,
    input  logic           chan_en,
    input  logic [N_E-1:0] ext_pulse,
    output logic           trig
);

    logic [N_I-1:0] int_req;

    // Purpose: qualify each internal request and combine all sources.
    always_comb begin
        int_req = int_stat & int_mask & {N_I{chan_en}};
        trig    = (|int_req) | (|ext_pulse);
    end

endmodule

// File: rtl/dma_req_select.sv
`timescale 1ns/1ps
// Module: DMA channel request selector (top).
// Stores the control word, synchronizes the external request pins and
// builds the transfer trigger from the sources selected by the mask field.
// Assumes a single clock domain; ext_pin may be asynchronous.
module dma_req_select
    import dma_rsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [N_INT-1:0]  int_stat,
    input  logic [N_EXT-1:0]  ext_pin,
    output logic              trig
);

    ctl_word_t          ctl;
    logic [N_EXT-1:0]   ext_pulse;

    dma_ctl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ctl      (ctl)
    );

    // One synchronizer and edge detector per external pin.
    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        dma_ext_edge #(
            .STAGES (SYNC_STAGES)
        ) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin[g]),
            .arm   (ctl.chan_en & ctl.req_mask[N_INT+g]),
            .pulse (ext_pulse[g])
        );
    end

    dma_trig_merge #(
        .N_I (N_INT),
        .N_E (N_EXT)
    ) u_merge (
        .int_stat  (int_stat),
        .int_mask  (ctl.req_mask[N_INT-1:0]),
        .chan_en   (ctl.chan_en),
        .ext_pulse (ext_pulse),
        .trig      (trig)
    );

    // Purpose: present the stored word, unused bits forced to zero.
    always_comb begin
        rd_data = WORD_W'(ctl) & ~RSV_BITS;
    end

endmodule

// File: rtl/dma_req_select_chk.sv
`timescale 1ns/1ps
// Module: port-level checker for dma_req_select, attached with bind.
module dma_req_select_chk
    import dma_rsel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic [N_INT-1:0]  int_stat,
    input logic [N_EXT-1:0]  ext_pin,
    input logic              trig
);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_data & RSV_BITS) == '0); // R3
    AST_WR_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !soft_rst) |=> rd_data == ($past(wr_data) & ~RSV_BITS)); // R2
    AST_NO_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!wr_en && !soft_rst) |=> $stable(rd_data)); // R2
    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> rd_data[16:8] == '0); // R9
    AST_INT_FIRES: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[31] && (|(int_stat & rd_data[13:8]))) |-> trig); // R6
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!rd_data[31] && !$past(rd_data[31])) |-> !trig); // R8

endmodule

bind dma_req_select dma_req_select_chk u_chk (.*);

// File: tb/dma_req_select_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs for the next
// cycle, and the monitor pops and compares them at each falling edge.
module dma_req_select_tb;

    logic        clk = 1'b0;
    logic        rst_n, soft_rst, wr_en, trig;
    logic [31:0] wr_data, rd_data;
    logic [5:0]  int_stat;
    logic [2:0]  ext_pin;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic        trig;
        logic [31:0] rd;
        bit          chk_rd;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    dma_req_select u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .int_stat(int_stat),
        .ext_pin(ext_pin), .trig(trig)
    );

    // Monitor: compare outputs with the oldest expectation.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (trig !== e.trig) begin
                n_fail++;
                $display("FAIL %s trig: actual %b expected %b", e.tag, trig, e.trig);
            end
            if (e.chk_rd) begin
                n_chk++;
                if (rd_data !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s rd_data: actual %h expected %h", e.tag, rd_data, e.rd);
                end
            end
        end
    end

    // Driver step: queue the expectation for the next cycle, then advance.
    task automatic step(input logic et, input logic [31:0] er, input bit cr, input string tag);
        exp_t e;
        e.trig = et; e.rd = er; e.chk_rd = cr; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] d, input logic et, input logic [31:0] er, input string tag);
        wr_en = 1'b1; wr_data = d;
        step(et, er, 1, tag);
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; soft_rst = 1'b0; wr_en = 1'b0; wr_data = '0;
        int_stat = '0; ext_pin = '0;
        @(negedge clk); #1;
        step(0, 32'h0, 1, "R1 reset");
        step(0, 32'h0, 1, "R1 reset");
        rst_n = 1'b1;

        // R3: reserved bits read zero.
        wr(32'hFFFF_FFFF, 0, 32'hD781_FF3F, "R3 all ones");
        // R4: field layout, reserved bits set in the write are dropped.
        wr(32'h8500_002A | 32'h287E_00C0, 0, 32'h8500_002A, "R4 layout");
        // R2: no write without the strobe.
        wr_data = 32'h1234_5678;
        step(0, 32'h8500_002A, 1, "R2 no write");

        // R6: internal source gated by the enable bit.
        int_stat = 6'b000011;
        wr(32'h0000_0100, 0, 32'h0000_0100, "R6 enable clear");
        wr(32'h8000_0100, 1, 32'h8000_0100, "R6 enabled");
        step(1, 0, 0, "R6 level held");
        step(1, 0, 0, "R6 level held");
        int_stat = 6'b000010;
        step(0, 0, 0, "R5 unmasked internal ignored");
        int_stat = 6'b100000;
        wr(32'h8000_2100, 1, 32'h8000_2100, "R10 source M5 in OR");
        int_stat = 6'b000000;
        step(0, 0, 0, "R10 no source");

        // R7: external edge gives one pulse at the third edge.
        wr(32'h8000_4000, 0, 32'h8000_4000, "R5 select pin0");
        ext_pin = 3'b001;
        step(0, 0, 0, "R7 sync stage 1");
        step(0, 0, 0, "R7 sync stage 2");
        step(1, 0, 0, "R7 pulse");
        step(0, 0, 0, "R7 single cycle");
        step(0, 0, 0, "R7 held high");
        ext_pin = 3'b000;
        for (int i = 0; i < 4; i++) step(0, 0, 0, "R7 falling edge");
        ext_pin = 3'b010;
        for (int i = 0; i < 4; i++) step(0, 0, 0, "R5 masked pin ignored");
        ext_pin = 3'b000;

        // R8: external edge while disabled is dropped.
        wr(32'h0000_4000, 0, 32'h0000_4000, "R8 disable");
        for (int i = 0; i < 3; i++) step(0, 0, 0, "R8 settle");
        ext_pin = 3'b001;
        for (int i = 0; i < 4; i++) step(0, 0, 0, "R8 edge while off");
        wr(32'h8000_4000, 0, 32'h8000_4000, "R8 enable");
        for (int i = 0; i < 4; i++) step(0, 0, 0, "R8 no stale pulse");
        ext_pin = 3'b000;

        // R9: soft reset clears only the mask field.
        wr(32'h8501_FF2A, 0, 32'h8501_FF2A, "R2 write");
        soft_rst = 1'b1;
        step(0, 32'h8500_002A, 1, "R9 soft reset");
        soft_rst = 1'b0;
        int_stat = 6'b000001;
        step(0, 32'h8500_002A, 1, "R9 source ignored after clear");
        int_stat = 6'b000000;

        rst_n = 1'b0;
        step(0, 32'h0, 1, "R1 reset again");
        rst_n = 1'b1;
        step(0, 32'h0, 1, "R1 after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule